// File: doc/BRIEF.md
# Composite Source-Select Clock Divider

This block derives one output clock from one of four clock sources. All logic runs on a single reference clock. Each source arrives as a one-cycle enable strobe on that clock. A 32-bit configuration word picks the source and sets two divide stages. The first stage is a pre-divider, and it sits in the path only for one designated source. The second stage is a post-divider, and it is always applied after the first.

The block emits two signals. The first is an output tick, a single-cycle strobe that marks the end of each output period. The second is a divided clock level.

The two stages are folded into one total ratio N, which equals the pre ratio times the post ratio. A single counter counts strobes of the selected source against N. The source selection and N are held in shadow state. That state reloads only on the last source strobe of the current period, so a change of configuration never produces a shortened period.

Software uses two write commands, and the current configuration word is always visible on the read port:
- A full write replaces the whole word.
- A rate write changes only the two divider fields.

Top module: `cdiv_composite`

## Requirements
- R1: Register bits [17:16] select which source strobe (index 0..3 of `src_tick_i`) is counted. Strobes of the other sources have no effect on the outputs.
- R2: When the selector equals 3, the pre-divide ratio is bits [12:8] plus one (1..32). For selectors 0, 1 and 2 the pre ratio is 1, whatever bits [12:8] hold.
- R3: The post-divide ratio is bits [5:4] plus one (1..4) for every selector.
- R4: Each output period lasts exactly N = pre x post strobes of the selected source. `out_tick_o` is high in the cycle of the last strobe of each period.
- R5: A rate write (`rate_we_i` high, `cfg_we_i` low) replaces only bits [12:8] and [5:4], that is mask 32'h0000_1F30. All other register bits keep their value. If both writes are requested in one cycle, the full write takes effect.
- R6: Bits outside [17:16], [12:8] and [5:4] read back on `cfg_rdata_o` as written and do not change the output timing.
- R7: A new selector or ratio takes effect only after the last strobe of the period in progress. That period completes with its old length.
- R8: When N = 1, `out_clk_o` equals the selected source strobe. When N > 1, `out_clk_o` is high during the first floor(N/2) strobes of each period and low for the rest.
- R9: Reset clears the register to zero. After reset, source 0 is selected with N = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_tick_i | input | 4 | One enable strobe per clock source |
| cfg_we_i | input | 1 | Full write of the configuration word |
| rate_we_i | input | 1 | Write of the two divider fields only |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Current configuration word |
| out_tick_o | output | 1 | Strobe on the last source strobe of each output period |
| out_clk_o | output | 1 | Divided clock level |

## Verification
The bench covers several cases, each aimed at a specific kind of fault:
- It sets junk in the pre-divide field while a bypassed source is selected. A design that applied the pre-divider everywhere would stretch those periods.
- It runs the extremes N = 1 and N = 128. A counter that was too narrow, or off by one at the wrap, would miscount those periods.
- It merges a rate write into a word that carries selector 3. A design that failed to preserve the selector would read back the wrong word and change its timing.
- It reconfigures ten strobes into a 128-strobe period. A design that reloaded at once would cut that period short.
- It counts high strobes per period. A design with the wrong duty rule would report the wrong count, for odd ratios and for N = 1 in particular.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int unsigned CFG_W    = 32;
  localparam int unsigned SEL_LSB  = 16;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned PRE_LSB  = 8;
  localparam int unsigned PRE_W    = 5;
  localparam int unsigned POST_LSB = 4;
  localparam int unsigned POST_W   = 2;
  localparam int unsigned RATIO_W  = PRE_W + POST_W + 2;

  localparam logic [CFG_W-1:0] PRE_MASK  = ((CFG_W'(1) << PRE_W) - CFG_W'(1)) << PRE_LSB;
  localparam logic [CFG_W-1:0] POST_MASK = ((CFG_W'(1) << POST_W) - CFG_W'(1)) << POST_LSB;
  localparam logic [CFG_W-1:0] RATE_MASK = PRE_MASK | POST_MASK;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [PRE_W-1:0]  pre;
    logic [POST_W-1:0] post;
  } cfg_t;

  function automatic cfg_t cfg_decode(input logic [CFG_W-1:0] w);
    cfg_t c;
    c.sel  = w[SEL_LSB +: SEL_W];
    c.pre  = w[PRE_LSB +: PRE_W];
    c.post = w[POST_LSB +: POST_W];
    return c;
  endfunction
endpackage

// File: rtl/cdiv_regfile.sv
module cdiv_regfile
  import cdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             rate_we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] q_o
);
  logic [CFG_W-1:0] q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (cfg_we_i) begin
      q <= wdata_i;
    end else if (rate_we_i) begin
      q <= (q & ~RATE_MASK) | (wdata_i & RATE_MASK);
    end
  end

  assign q_o = q;

  // R5
  sel_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_we_i && !cfg_we_i) |=> (q_o & ~RATE_MASK) == ($past(q_o) & ~RATE_MASK));
endmodule

// File: rtl/cdiv_ratio.sv
module cdiv_ratio
  import cdiv_pkg::*;
#(
  parameter int unsigned PRE_SRC = 3
) (
  input  cfg_t               cfg_i,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [PRE_W:0]  pre_eff;
  logic [POST_W:0] post_eff;

  always_comb begin
    if (cfg_i.sel == SEL_W'(PRE_SRC)) pre_eff = {1'b0, cfg_i.pre} + (PRE_W+1)'(1);
    else                              pre_eff = (PRE_W+1)'(1);
    post_eff = {1'b0, cfg_i.post} + (POST_W+1)'(1);
  end

  assign ratio_o = RATIO_W'(pre_eff) * RATIO_W'(post_eff);
endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter
  import cdiv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [RATIO_W-1:0] ratio_next_i,
  input  logic [SEL_W-1:0]   sel_next_i,
  output logic [SEL_W-1:0]   act_sel_o,
  output logic               out_tick_o,
  output logic               out_clk_o
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] act_n;
  logic [SEL_W-1:0]   act_sel;
  logic               last;
  logic               wrap;

  assign last = (cnt == act_n - RATIO_W'(1));
  assign wrap = tick_i && last;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt     <= '0;
      act_n   <= RATIO_W'(1);
      act_sel <= '0;
    end else if (wrap) begin
      cnt     <= '0;
      act_n   <= ratio_next_i;
      act_sel <= sel_next_i;
    end else if (tick_i) begin
      cnt <= cnt + RATIO_W'(1);
    end
  end

  assign act_sel_o  = act_sel;
  assign out_tick_o = wrap;
  assign out_clk_o  = (act_n == RATIO_W'(1)) ? tick_i : (cnt < (act_n >> 1));

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < act_n);

  // R4
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> cnt == '0);

  // R7
  hold_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> ($stable(act_n) && $stable(act_sel)));
endmodule

// File: rtl/cdiv_composite.sv
module cdiv_composite
  import cdiv_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned PRE_SRC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic               cfg_we_i,
  input  logic               rate_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic [CFG_W-1:0]   cfg_rdata_o,
  output logic               out_tick_o,
  output logic               out_clk_o
);
  logic [CFG_W-1:0]   cfg_q;
  cfg_t               cfg;
  logic [RATIO_W-1:0] ratio;
  logic [SEL_W-1:0]   act_sel;
  logic [NUM_SRC-1:0] hit;
  logic               sel_tick;

  cdiv_regfile u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (cfg_we_i),
    .rate_we_i (rate_we_i),
    .wdata_i   (cfg_wdata_i),
    .q_o       (cfg_q)
  );

  assign cfg = cfg_decode(cfg_q);

  cdiv_ratio #(.PRE_SRC(PRE_SRC)) u_ratio (
    .cfg_i   (cfg),
    .ratio_o (ratio)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = src_tick_i[g] && (act_sel == SEL_W'(g));
  end
  assign sel_tick = |hit;

  cdiv_counter u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (sel_tick),
    .ratio_next_i (ratio),
    .sel_next_i   (cfg.sel),
    .act_sel_o    (act_sel),
    .out_tick_o   (out_tick_o),
    .out_clk_o    (out_clk_o)
  );

  assign cfg_rdata_o = cfg_q;

  // R1
  tick_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_tick_o |-> src_tick_i[act_sel]);
endmodule

// File: tb/cdiv_composite_bench.sv
module cdiv_composite_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src = 4'b0;
  logic        cfg_we = 1'b0;
  logic        rate_we = 1'b0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        out_tick;
  logic        out_clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int cyc = 0;

  localparam int K = 3;
  localparam int NV = 8;
  localparam logic [31:0] VW [NV] = '{
    32'h0000_0000, 32'h0001_0510, 32'h0002_1F30, 32'h0003_0000,
    32'h0003_0400, 32'h0003_1F30, 32'h0003_0220, 32'hF0F0_07A5};
  localparam int VN [NV] = '{1, 2, 4, 1, 5, 128, 9, 3};

  always #2 clk = ~clk;

  cdiv_composite u_cdiv_composite (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .src_tick_i  (src),
    .cfg_we_i    (cfg_we),
    .rate_we_i   (rate_we),
    .cfg_wdata_i (cfg_wdata),
    .cfg_rdata_o (cfg_rdata),
    .out_tick_o  (out_tick),
    .out_clk_o   (out_clk)
  );

  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      src[0] = (cyc % 2 == 0);
      src[1] = (cyc % 3 == 0);
      src[2] = (cyc % 5 == 0);
      src[3] = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic full_write(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic measure(input int sel, input int n, input string req);
    int ticks = 0;
    int hi = 0;
    int per = 0;
    int exp_hi;
    do @(negedge clk); while (!out_tick);
    while (per < K) begin
      @(negedge clk);
      if (src[sel]) begin
        ticks++;
        if (out_clk) hi++;
      end
      if (out_tick) per++;
    end
    exp_hi = (n == 1) ? K : K * (n / 2);
    check(ticks == K * n, req, ticks, K * n);
    check(hi == exp_hi, "R8 duty", hi, exp_hi);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w5;
    logic [31:0] d5;
    logic [31:0] e5;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: register clears, source 0 with N = 1
    check(cfg_rdata == 32'h0, "R9 reset value", cfg_rdata, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(out_tick == src[0], "R9 tick follows source 0", out_tick, src[0]);
      check(out_clk == src[0], "R8 N=1 clock follows strobe", out_clk, src[0]);
    end

    // vector table: R1 R2 R3 R4 R6
    for (int v = 0; v < NV; v++) begin
      full_write(VW[v]);
      check(cfg_rdata == VW[v], "R6 readback", cfg_rdata, VW[v]);
      measure(int'(VW[v][17:16]), VN[v], "R1/R2/R3/R4 period length");
    end

    // R5: rate write keeps selector and other bits
    w5 = 32'h8B03_E1C7;
    d5 = 32'h0000_1F30;
    e5 = (w5 & ~32'h0000_1F30) | (d5 & 32'h0000_1F30);
    full_write(w5);
    measure(3, 2, "R2 pre ratio 2");
    @(negedge clk);
    rate_we = 1'b1;
    cfg_wdata = d5;
    @(negedge clk);
    rate_we = 1'b0;
    check(cfg_rdata == e5, "R5 merged word", cfg_rdata, e5);
    measure(3, 128, "R5 rate write period");

    // R5: both writes at once, full write wins
    @(negedge clk);
    cfg_we = 1'b1;
    rate_we = 1'b1;
    cfg_wdata = 32'h0003_1F30;
    @(negedge clk);
    cfg_we = 1'b0;
    rate_we = 1'b0;
    check(cfg_rdata == 32'h0003_1F30, "R5 full write priority", cfg_rdata, 32'h0003_1F30);
    measure(3, 128, "R4 max ratio");

    // R7: change mid-period, current period keeps 128 strobes
    begin
      int t = 0;
      bit wrote = 1'b0;
      bit clr = 1'b0;
      forever begin
        @(negedge clk);
        if (clr) begin
          cfg_we = 1'b0;
          clr = 1'b0;
        end
        if (src[3]) t++;
        if (t == 10 && !wrote) begin
          cfg_we = 1'b1;
          cfg_wdata = 32'h0001_0010;
          wrote = 1'b1;
          clr = 1'b1;
        end
        if (out_tick) break;
      end
      cfg_we = 1'b0;
      check(t == 128, "R7 period completes at old length", t, 128);
    end
    measure(1, 2, "R7 new setting after boundary");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule